// File: doc/BRIEF.md
# Receive Frame Buffer Packer

This block sits between the receive side of an Ethernet MAC and a 16-bit packet memory. Frame bytes arrive one per accepted beat, and the block stores them as they come. Each packet in memory has four parts: a status word, a byte count word, the frame bytes, and a trailing control word. Every byte, including both addresses and the length/type field, is stored exactly as received. The block reads none of them.

When the last byte is accepted, the block also captures the end-of-frame flags. These are the CRC result, the nibble parity, the too-long and too-short indications, broadcast, multicast and a 6-bit hash index. The block then writes the control word. After that it goes back to the head of the packet and writes the byte count word, then the status word. One cycle after the status write, it pulses `done`.

While those trailing writes are in progress, `in_ready` is low and the input stream is held off. A frame that runs past the data limit stops storing bytes and is flagged as too long.

Top module: `rx_frame_packer`

## Requirements
- R1: Frame byte i (counted from 0) is written to word `base+2+i/2`. It goes in the low byte when i is even and in the high byte when i is odd.
- R2: The control word sits at `base+2+floor(N/2)`, where N is the number of stored bytes.
  - Its high byte is 0x20 (bit 5 = ODD) when N is odd, and 0x00 when N is even.
  - Its low byte is the last frame byte when N is odd, and 0x00 when N is even.
- R3: The word at `base+1` holds the packet byte count `2*(3+floor(N/2))`. This covers the status, count, data and control bytes, rounded up to even, so bit 0 is always 0.
- R4: The word at `base` is the status word, laid out as follows:
  - bit 15: alignment error
  - bit 14: broadcast
  - bit 13: bad CRC
  - bit 12: odd frame
  - bit 11: too long
  - bit 10: too short
  - bits 9..7: zero
  - bits 6..1: hash index
  - bit 0: multicast
- R5: The alignment error bit is 1 only when the bad-CRC flag and the odd-nibble flag are both set. An odd nibble count with a good CRC gives 0.
- R6: The odd-frame status bit equals bit 0 of N.
- R7: Bytes that arrive after `MAX_DATA` (default 2043) bytes have been stored are dropped and never written. Such a frame gets the too-long status bit, which is also set when `in_too_long` is high at the last byte.
- R8: The trailing writes come on three back-to-back cycles after the last byte is accepted, in this order: control word, count word, status word. `done` is high for exactly one cycle, the cycle after the status write. Each frame makes exactly `floor(N/2)+3` writes.
- R9: From the cycle after the last byte is accepted until `done` has been given, `in_ready` is low. Beats offered during that time have no effect on memory or on the next frame.
- R10: After reset, `mem_we` and `done` are 0 and `in_ready` is 1. A frame cut off by reset leaves no state behind, so the next frame is stored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame byte is offered |
| in_ready | output | 1 | The block can take a byte |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of the frame |
| in_crc_bad | input | 1 | CRC check failed (sampled with the last byte) |
| in_odd_nibbles | input | 1 | An odd number of nibbles was received (sampled with the last byte) |
| in_bcast | input | 1 | Broadcast destination (sampled with the last byte) |
| in_mcast | input | 1 | Multicast destination (sampled with the last byte) |
| in_hash | input | 6 | Hash index (sampled with the last byte) |
| in_too_long | input | 1 | MAC-side too-long indication (sampled with the last byte) |
| in_too_short | input | 1 | MAC-side too-short indication (sampled with the last byte) |
| in_base | input | ADDR_W | Word address of the packet, sampled with the first byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | ADDR_W | Packet memory word address |
| mem_wdata | output | 16 | Packet memory write data |
| done | output | 1 | One-cycle pulse after the packet is complete |

## Verification
Two things can fall on the same clock edge:
- For an even-length frame, the write of the last data pair happens on the same edge that captures the end-of-frame flags and leaves the receive state.
- In an over-long frame, the byte cap is reached in the same frame that ends with `in_last`.

The bench drives both cases, with frames of every parity and a 2047-byte frame. It judges them by the exact number of writes, the final write order, the control word contents and an untouched guard word past the cap. Beats offered during the trailing writes test that the busy window blocks input.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic [2:0] {
        PK_RECV,
        PK_CTRL,
        PK_COUNT,
        PK_STAT,
        PK_FIN
    } pk_state_e;

    typedef struct packed {
        logic       crc_bad;
        logic       odd_nib;
        logic       bcast;
        logic       mcast;
        logic       too_long;
        logic       too_short;
        logic [5:0] hash;
    } rx_flags_t;

    // words ahead of the data area: status and count
    localparam int unsigned HDR_WORDS = 2;
    localparam logic [7:0]  CTRL_ODD  = 8'h20;

    function automatic logic [15:0] pack_status(rx_flags_t f, logic odd, logic ovf);
        logic [15:0] w;
        w     = '0;
        w[15] = f.crc_bad & f.odd_nib;
        w[14] = f.bcast;
        w[13] = f.crc_bad;
        w[12] = odd;
        w[11] = f.too_long | ovf;
        w[10] = f.too_short;
        w[6:1] = f.hash;
        w[0]  = f.mcast;
        return w;
    endfunction

endpackage

// File: rtl/rxpk_byte_track.sv
module rxpk_byte_track #(
    parameter int MAX_DATA = 2043,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             accept,
    input  logic [7:0]       byte_in,
    output logic [CNT_W-1:0] nbytes,
    output logic [7:0]       held,
    output logic             store,
    output logic             ovf
);
    logic full;

    assign full  = (nbytes == CNT_W'(MAX_DATA));
    assign store = accept & ~full;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            nbytes <= '0;
            held   <= '0;
            ovf    <= 1'b0;
        end else begin
            if (store) begin
                nbytes <= nbytes + 1'b1;
                if (!nbytes[0])
                    held <= byte_in;
            end
            if (accept && full)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rxpk_hdr_fmt.sv
module rxpk_hdr_fmt
    import rxpk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 11
) (
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [7:0]        held,
    input  logic              ovf,
    input  rx_flags_t         flags,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] ctrl_addr,
    output logic [15:0]       ctrl_word,
    output logic [15:0]       count_word,
    output logic [15:0]       status_word
);
    logic [CNT_W-2:0] half;
    logic             odd;

    assign half        = nbytes[CNT_W-1:1];
    assign odd         = nbytes[0];
    assign ctrl_addr   = base + ADDR_W'(HDR_WORDS) + ADDR_W'(half);
    assign ctrl_word   = {(odd ? CTRL_ODD : 8'h00), (odd ? held : 8'h00)};
    assign count_word  = {15'(half) + 15'(HDR_WORDS + 1), 1'b0};
    assign status_word = pack_status(flags, odd, ovf);
endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
    import rxpk_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MAX_DATA = 2043
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    input  logic              in_crc_bad,
    input  logic              in_odd_nibbles,
    input  logic              in_bcast,
    input  logic              in_mcast,
    input  logic [5:0]        in_hash,
    input  logic              in_too_long,
    input  logic              in_too_short,
    input  logic [ADDR_W-1:0] in_base,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              done
);
    localparam int CNT_W = $clog2(MAX_DATA + 1);

    pk_state_e         state;
    logic [ADDR_W-1:0] base_q;
    rx_flags_t         flags_q;
    rx_flags_t         flags_in;
    logic              accept;
    logic              store;
    logic              ovf;
    logic [CNT_W-1:0]  nbytes;
    logic [7:0]        held;
    logic [ADDR_W-1:0] ctrl_addr;
    logic [15:0]       ctrl_word;
    logic [15:0]       count_word;
    logic [15:0]       status_word;

    assign in_ready = (state == PK_RECV);
    assign accept   = in_valid & in_ready;

    always_comb begin
        flags_in.crc_bad   = in_crc_bad;
        flags_in.odd_nib   = in_odd_nibbles;
        flags_in.bcast     = in_bcast;
        flags_in.mcast     = in_mcast;
        flags_in.too_long  = in_too_long;
        flags_in.too_short = in_too_short;
        flags_in.hash      = in_hash;
    end

    rxpk_byte_track #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .clear  (state == PK_FIN),
        .accept (accept),
        .byte_in(in_byte),
        .nbytes (nbytes),
        .held   (held),
        .store  (store),
        .ovf    (ovf)
    );

    rxpk_hdr_fmt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fmt (
        .nbytes     (nbytes),
        .held       (held),
        .ovf        (ovf),
        .flags      (flags_q),
        .base       (base_q),
        .ctrl_addr  (ctrl_addr),
        .ctrl_word  (ctrl_word),
        .count_word (count_word),
        .status_word(status_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PK_RECV;
            base_q    <= '0;
            flags_q   <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                PK_RECV: begin
                    if (accept) begin
                        if (nbytes == '0)
                            base_q <= in_base;
                        if (store && nbytes[0]) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= base_q + ADDR_W'(HDR_WORDS)
                                         + ADDR_W'(nbytes[CNT_W-1:1]);
                            mem_wdata <= {in_byte, held};
                        end
                        if (in_last) begin
                            flags_q <= flags_in;
                            state   <= PK_CTRL;
                        end
                    end
                end
                PK_CTRL: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= ctrl_addr;
                    mem_wdata <= ctrl_word;
                    state     <= PK_COUNT;
                end
                PK_COUNT: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q + ADDR_W'(1);
                    mem_wdata <= count_word;
                    state     <= PK_STAT;
                end
                PK_STAT: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q;
                    mem_wdata <= status_word;
                    state     <= PK_FIN;
                end
                PK_FIN: begin
                    done  <= 1'b1;
                    state <= PK_RECV;
                end
                default: state <= PK_RECV;
            endcase
        end
    end
endmodule

// File: rtl/rx_frame_packer_chk.sv
module rx_frame_packer_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic        mem_we,
    input logic [15:0] mem_wdata,
    input logic        done
);
    // R10: idle outputs right after reset
    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_we && !done && in_ready));

    // R9: busy window opens after the last byte
    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done follows a write (the status word)
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_we));

    // R3: count word written two cycles before done is even
    assert_count_even_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we, 2) && !$past(mem_wdata[0], 2)));

    // R5: alignment error only with bad CRC
    assert_algn_needs_crc_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!$past(mem_wdata[15]) || $past(mem_wdata[13])));
endmodule

bind rx_frame_packer rx_frame_packer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .done     (done)
);

// File: tb/rx_frame_packer_test.sv
module rx_frame_packer_test;
    localparam int AW   = 12;
    localparam int MAXD = 2043;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, in_valid, in_ready, in_last;
    logic [7:0]    in_byte;
    logic          in_crc_bad, in_odd_nibbles, in_bcast, in_mcast, in_too_long, in_too_short;
    logic [5:0]    in_hash;
    logic [AW-1:0] in_base;
    logic          mem_we, done;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;

    rx_frame_packer #(.ADDR_W(AW), .MAX_DATA(MAXD)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_last(in_last), .in_crc_bad(in_crc_bad),
        .in_odd_nibbles(in_odd_nibbles), .in_bcast(in_bcast), .in_mcast(in_mcast),
        .in_hash(in_hash), .in_too_long(in_too_long), .in_too_short(in_too_short),
        .in_base(in_base), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done)
    );

    logic [15:0]   mem [0:(1<<AW)-1];
    int            n_chk = 0, n_bad = 0, wr_cnt = 0, done_cnt = 0;
    logic [AW-1:0] log0, log1, log2, last_addr, done_prev_addr;
    logic          last_we = 1'b0, done_prev_we = 1'b0;

    typedef struct packed {
        logic [11:0] len;
        logic crc; logic nib; logic bc; logic mc; logic tl; logic ts;
        logic [5:0] hash;
        logic gap; logic junk;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'd1,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 6'd0,  1'b0,1'b0},
        '{12'd2,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 6'd5,  1'b0,1'b1},
        '{12'd14, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 6'd63, 1'b1,1'b0},
        '{12'd15, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 6'd42, 1'b0,1'b0},
        '{12'd60, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 6'd21, 1'b0,1'b1},
        '{12'd64, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 6'd1,  1'b1,1'b0},
        '{12'd65, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 6'd3,  1'b0,1'b0},
        '{12'd3,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 6'd0,  1'b1,1'b1}
    };

    function automatic logic [7:0] bval(int seed, int i);
        return 8'((seed * 29) + (i * 13) + (i >> 4));
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
            log2 = log1; log1 = log0; log0 = mem_addr;
        end
        if (done) begin
            done_cnt++;
            done_prev_we   = last_we;
            done_prev_addr = last_addr;
        end
        last_we   = mem_we;
        last_addr = mem_addr;
    endtask

    task automatic run_frame(vec_t v, logic [AW-1:0] base, int seed);
        int n, half;
        logic odd, ovf;
        logic [15:0] exp_ctrl, exp_cnt, exp_st;
        logic [AW-1:0] caddr;
        wr_cnt = 0; done_cnt = 0;
        in_base = base;
        in_crc_bad = v.crc; in_odd_nibbles = v.nib; in_bcast = v.bc;
        in_mcast = v.mc; in_too_long = v.tl; in_too_short = v.ts; in_hash = v.hash;
        for (int i = 0; i < int'(v.len); i++) begin
            if (v.gap && (i % 3 == 2)) begin in_valid = 1'b0; tick(); end
            in_valid = 1'b1; in_byte = bval(seed, i); in_last = (i == int'(v.len) - 1);
            tick();
        end
        in_valid = 1'b0; in_last = 1'b0;
        if (v.junk) begin
            for (int k = 0; k < 3; k++) begin
                in_valid = 1'b1; in_byte = 8'hEE; in_last = (k == 2);
                check(in_ready == 1'b0, "R9", "ready during trailing writes", in_ready, 0);
                tick();
            end
            in_valid = 1'b0; in_last = 1'b0;
        end
        for (int t = 0; t < 12 && done_cnt == 0; t++) tick();
        tick(); tick();

        n    = (int'(v.len) > MAXD) ? MAXD : int'(v.len);
        half = n / 2;
        odd  = n[0];
        ovf  = int'(v.len) > MAXD;
        caddr = base + AW'(2 + half);
        for (int j = 0; j < half; j++)
            check(mem[base + AW'(2 + j)] == {bval(seed, 2*j+1), bval(seed, 2*j)},
                  "R1", "data word", mem[base + AW'(2 + j)], {bval(seed, 2*j+1), bval(seed, 2*j)});
        exp_ctrl = {(odd ? 8'h20 : 8'h00), (odd ? bval(seed, n-1) : 8'h00)};
        check(mem[caddr] == exp_ctrl, "R2", "control word", mem[caddr], exp_ctrl);
        exp_cnt = 16'(2 * (half + 3));
        check(mem[base + AW'(1)] == exp_cnt, "R3", "count word", mem[base + AW'(1)], exp_cnt);
        exp_st = {v.crc & v.nib, v.bc, v.crc, odd, v.tl | ovf, v.ts, 3'b000, v.hash, v.mc};
        check(mem[base] == exp_st, "R4", "status word", mem[base], exp_st);
        check(mem[base][15] == (v.crc & v.nib), "R5", "alignment bit", mem[base][15], v.crc & v.nib);
        check(mem[base][12] == odd, "R6", "odd-frame bit", mem[base][12], odd);
        check(mem[base][11] == (v.tl | ovf), "R7", "too-long bit", mem[base][11], v.tl | ovf);
        check(wr_cnt == half + 3, "R8", "write count", wr_cnt, half + 3);
        check(log0 == base && log1 == base + AW'(1) && log2 == caddr, "R8", "trailing write order",
              {log2, log1, log0}, {caddr, base + AW'(1), base});
        check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
        check(done_prev_we && done_prev_addr == base, "R8", "done after status write",
              {done_prev_we, done_prev_addr}, {1'b1, base});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t lv;
        for (int a = 0; a < (1 << AW); a++) mem[a] = 16'hDEAD;
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_byte = '0; in_base = '0;
        in_crc_bad = 0; in_odd_nibbles = 0; in_bcast = 0; in_mcast = 0;
        in_too_long = 0; in_too_short = 0; in_hash = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check(mem_we == 1'b0 && done == 1'b0 && in_ready == 1'b1, "R10", "reset state",
              {mem_we, done, in_ready}, 3'b001);

        for (int k = 0; k < 8; k++)
            run_frame(VECS[k], AW'(k * 64 + 5), k + 1);

        // R7: over-long frame, cap hit before in_last
        lv = '{12'd2047, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9, 1'b0, 1'b0};
        run_frame(lv, AW'(2048), 99);
        check(mem[AW'(2048 + 3 + MAXD/2)] == 16'hDEAD, "R7", "guard word past cap",
              mem[AW'(2048 + 3 + MAXD/2)], 16'hDEAD);

        // R10: reset in mid-frame, then a clean frame
        in_base = AW'(3000);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_byte = 8'h55 + 8'(i); in_last = 1'b0; tick();
        end
        in_valid = 1'b0;
        rst = 1'b1; tick(); tick();
        rst = 1'b0; tick();
        check(mem_we == 1'b0 && done == 1'b0 && in_ready == 1'b1, "R10", "idle after mid-frame reset",
              {mem_we, done, in_ready}, 3'b001);
        lv = '{12'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd17, 1'b0, 1'b0};
        run_frame(lv, AW'(3100), 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule